// File: doc/BRIEF.md
# Video Memory Address Decoder with Nametable Folding

This block sits between a tile-based video engine and its local memories. It takes a 14-bit address with an 8-bit data bus and sends each access to one of three targets: the tile-pattern ROM in the low 8 KB, the nametable RAM in the middle, or a small palette RAM at the top. The block holds the 2 KB nametable RAM and the 32-entry palette RAM. The pattern ROM sits outside the block and is read without a clock: the block drives its address and registers the byte that comes back.

The nametable window holds four logical 1 KB screens at 0x2000, 0x2400, 0x2800 and 0x2C00. Each screen is 32 by 30 one-byte tile references, which is 960 bytes. Only two physical 1 KB banks exist, so a one-bit mode input decides which logical screens share a bank. In vertical folding the bank is chosen by address bit 10. In horizontal folding it is chosen by address bit 11. Addresses 0x3000 to 0x3EFF repeat the nametable window. The palette page at 0x3F00 to 0x3FFF repeats every 32 bytes.

A read request returns its byte one clock later, with a valid strobe. A write to either RAM takes effect on the clock edge that captures it.

Top module: `vbus_decoder`

## Requirements
- R1: After synchronous reset, `rd_valid` and `rd_data` are 0, and every palette entry reads back as 0.
- R2: A read at an address with bit 13 clear drives `pat_addr` with address bits [12:0]. The cycle after the request, `rd_data` returns the byte the pattern ROM supplied.
- R3: A write to the pattern range (bit 13 clear) changes neither the palette nor the nametable RAM, including the entries whose low address bits match the write.
- R4: With `mirror_horz`=0 (vertical folding), the physical nametable index is address bits [10:0]. Logical screens 0 and 2 then share storage, and screens 1 and 3 share the other bank.
- R5: With `mirror_horz`=1 (horizontal folding), the physical index is {bit 11, bits [9:0]}. Logical screens 0 and 1 then share storage, and screens 2 and 3 share the other bank.
- R6: Addresses 0x3000 to 0x3EFF reach the same nametable storage as the address 0x1000 below them. 0x3EFF is the last nametable address.
- R7: Addresses 0x3F00 to 0x3FFF select the palette by address bits [4:0], so every 32-byte step of that page reaches the same entry.
- R8: A palette entry is 6 bits. Bits [7:6] of a write are dropped and always read back as 0.
- R9: `rd_valid` is high in exactly the cycle after each accepted read (`req_valid`=1, `req_write`=0) and low at all other times, including after writes.
- R10: Changing `mirror_horz` changes only the address mapping. Bytes already stored stay in place and can be reached under the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mirror_horz | input | 1 | Nametable folding: 0 = vertical, 1 = horizontal |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Video address |
| req_wdata | input | 8 | Write data |
| pat_addr | output | 13 | Address to the external pattern ROM |
| pat_data | input | 8 | Byte returned by the pattern ROM for `pat_addr` without a clock |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data |

## Verification
The bench writes different bytes into the nametable under each folding mode and reads them back through every logical screen and through the 0x3000 repeat.

It catches these faults:
- A swapped bank bit returns the neighbouring screen's byte.
- An off-by-one end to the nametable window lets 0x3EFF land in the palette.
- A mode switch that resets or moves storage loses the bytes already written.

On the palette it checks:
- The 32-byte repeat across the 0x3F page; a decoder that used too many index bits would read uninitialised entries.
- That the two dropped high bits read back as zero.

A write to the pattern range is aimed at the same low bits as entries that already hold known values. A decoder that let such writes fall through would corrupt those entries.

// File: rtl/vbus_pkg.sv
// Package: shared region and folding-mode types for the video address decoder.
// Assumes: a 14-bit video address space with three target regions.
package vbus_pkg;

    typedef enum logic [1:0] {
        RGN_PAT = 2'd0,
        RGN_NT  = 2'd1,
        RGN_PAL = 2'd2
    } rgn_e;

    typedef enum logic {
        FOLD_VERT = 1'b0,
        FOLD_HORZ = 1'b1
    } fold_e;

endpackage

// File: rtl/vbus_addr_map.sv
// Module: vbus_addr_map
// Combinational decode of a video address into a region and the physical
// indices for the nametable and palette RAMs.
// Assumes: ADDR_W = PAT_AW + 1. The palette page is the top 256 bytes.
// The nametable bank bit sits just above the 1 KB offset (vertical folding)
// or one bit higher (horizontal folding).
module vbus_addr_map
    import vbus_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PAT_AW = 13,
    parameter int NT_AW  = 11,
    parameter int PAL_AW = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  fold_e             fold,
    output rgn_e              rgn,
    output logic [NT_AW-1:0]  nt_idx,
    output logic [PAL_AW-1:0] pal_idx
);
    localparam int NT_OFS  = NT_AW - 1;
    localparam int PAGE_LO = 8;
    localparam int PAGE_W  = ADDR_W - PAGE_LO;

    logic unused_addr_bits;

    // Region select: low half is pattern, top page is palette, rest nametable.
    always_comb begin
        if (!addr[ADDR_W-1])
            rgn = RGN_PAT;
        else if (addr[ADDR_W-1:PAGE_LO] == {PAGE_W{1'b1}})
            rgn = RGN_PAL;
        else
            rgn = RGN_NT;
    end

    // Nametable folding: the bank bit is picked by the folding mode.
    always_comb begin
        if (fold == FOLD_HORZ)
            nt_idx = {addr[NT_AW], addr[NT_OFS-1:0]};
        else
            nt_idx = addr[NT_AW-1:0];
    end

    // Palette index: only the low bits matter, the page repeats.
    assign pal_idx = addr[PAL_AW-1:0];

    assign unused_addr_bits = ^addr[PAGE_LO-1:PAL_AW] ^ ^addr[ADDR_W-2:NT_AW+1];

endmodule

// File: rtl/vbus_nt_ram.sv
// Module: vbus_nt_ram
// Single-port nametable RAM with a synchronous write and a registered read.
// Assumes: read and write never fall in the same cycle (the top issues one
// access per cycle). The contents are not reset.
module vbus_nt_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage update and registered read port.
    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
        if (re)
            rdata <= mem[idx];
    end

endmodule

// File: rtl/vbus_pal_ram.sv
// Module: vbus_pal_ram
// Small palette store of narrow entries, cleared by reset, with a registered
// read port.
// Assumes: the entry width is below the bus width. The caller pads on read.
module vbus_pal_ram #(
    parameter int AW = 5,
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] ent [DEPTH];

    // Per-entry storage, cleared on reset, loaded on a matching write.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && idx == AW'(g))
                ent[g] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= ent[idx];
    end

endmodule

// File: rtl/vbus_decoder.sv
// Module: vbus_decoder (top)
// Routes video-bus reads and writes to the external pattern ROM, the
// internal nametable RAM (two 1 KB banks folded from four logical screens)
// or the internal palette RAM. A read returns its data one cycle later.
// Assumes: the pattern ROM answers pat_addr without a clock, and at most one
// access is issued per cycle.
module vbus_decoder
    import vbus_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int NT_AW  = 11,
    parameter int PAL_AW = 5,
    parameter int PAL_EW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mirror_horz,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-2:0] pat_addr,
    input  logic [DATA_W-1:0] pat_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAT_AW = ADDR_W - 1;
    localparam int PAD_W  = DATA_W - PAL_EW;

    rgn_e              rgn, rgn_q;
    logic [NT_AW-1:0]  nt_idx;
    logic [PAL_AW-1:0] pal_idx;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] nt_q, pat_q;
    logic [PAL_EW-1:0] pal_q;
    logic              unused_wdata_hi;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid &&  req_write;

    vbus_addr_map #(
        .ADDR_W(ADDR_W), .PAT_AW(PAT_AW), .NT_AW(NT_AW), .PAL_AW(PAL_AW)
    ) map_i (
        .addr    (req_addr),
        .fold    (fold_e'(mirror_horz)),
        .rgn     (rgn),
        .nt_idx  (nt_idx),
        .pal_idx (pal_idx)
    );

    vbus_nt_ram #(.AW(NT_AW), .DW(DATA_W)) nt_i (
        .clk   (clk),
        .we    (wr_req && rgn == RGN_NT),
        .re    (rd_req && rgn == RGN_NT),
        .idx   (nt_idx),
        .wdata (req_wdata),
        .rdata (nt_q)
    );

    vbus_pal_ram #(.AW(PAL_AW), .EW(PAL_EW)) pal_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_req && rgn == RGN_PAL),
        .re    (rd_req && rgn == RGN_PAL),
        .idx   (pal_idx),
        .wdata (req_wdata[PAL_EW-1:0]),
        .rdata (pal_q)
    );

    assign unused_wdata_hi = ^req_wdata[DATA_W-1:PAL_EW];

    // Pattern ROM address: the low bits pass straight through.
    assign pat_addr = req_addr[PAT_AW-1:0];

    // Read pipeline: valid strobe, region tag and captured ROM byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rgn_q    <= RGN_PAT;
            pat_q    <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rgn_q <= rgn;
                pat_q <= pat_data;
            end
        end
    end

    // Return mux: choose the source by the region tag of the read.
    always_comb begin
        if (!rd_valid)
            rd_data = '0;
        else begin
            unique case (rgn_q)
                RGN_NT:  rd_data = nt_q;
                RGN_PAL: rd_data = {{PAD_W{1'b0}}, pal_q};
                default: rd_data = pat_q;
            endcase
        end
    end

    p_valid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_no_valid_without_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_valid && rd_data == '0));
    p_pal_high_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rgn_q == RGN_PAL) |-> rd_data[DATA_W-1:PAL_EW] == '0);
    p_pat_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !req_addr[ADDR_W-1]) |=> rd_data == $past(pat_data));

endmodule

// File: tb/vbus_decoder_tb_top.sv
`timescale 1ns/1ps
module vbus_decoder_tb_top;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mirror_horz = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [12:0] pat_addr;
    logic [7:0]  pat_data;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    assign pat_data = rom_byte(pat_addr);

    vbus_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .mirror_horz(mirror_horz),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .pat_addr(pat_addr), .pat_data(pat_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [13:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        sb_q.push_back('{exp: e, tag: tag});
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Monitor: pops one expected item per returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9: actual rd_valid 1 expected 0 (no read pending)");
            end else begin
                item_t it;
                it = sb_q.pop_front();
                compare(rd_data, it.exp, it.tag);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        compare({7'd0, rd_valid}, 8'h00, "R1 rd_valid after reset");
        compare(rd_data, 8'h00, "R1 rd_data after reset");
        bus_read(14'h3F07, 8'h00, "R1 palette cleared");
        bus_read(14'h3F00, 8'h00, "R1 palette entry 0 cleared");

        // Pattern ROM reads
        bus_read(14'h0000, rom_byte(13'h0000), "R2 pattern 0x0000");
        bus_read(14'h1ABC, rom_byte(13'h1ABC), "R2 pattern 0x1ABC");
        bus_read(14'h1FFF, rom_byte(13'h1FFF), "R2 pattern top");

        // Vertical folding (r4_)
        mirror_horz = 1'b0;
        bus_write(14'h2010, 8'h11);
        bus_write(14'h2410, 8'h22);
        @(negedge clk);
        compare({7'd0, rd_valid}, 8'h00, "R9 no valid after write");
        bus_read(14'h2810, 8'h11, "R4 screen2 shares screen0");
        bus_read(14'h2C10, 8'h22, "R4 screen3 shares screen1");
        bus_read(14'h3010, 8'h11, "R6 0x3010 repeats 0x2010");
        bus_read(14'h3C10, 8'h22, "R6 0x3C10 repeats 0x2C10");

        // Horizontal folding (r5_)
        mirror_horz = 1'b1;
        bus_write(14'h2020, 8'h33);
        bus_write(14'h2820, 8'h44);
        bus_read(14'h2420, 8'h33, "R5 screen1 shares screen0");
        bus_read(14'h2C20, 8'h44, "R5 screen3 shares screen2");
        bus_read(14'h3420, 8'h33, "R6 0x3420 repeats 0x2420");
        bus_read(14'h2410, 8'h11, "R10 old byte under new mapping");
        bus_read(14'h2810, 8'h22, "R10 old bank1 byte under new mapping");
        bus_write(14'h3EFF, 8'h5C);
        bus_read(14'h2EFF, 8'h5C, "R6 0x3EFF is nametable");

        // Palette (r7_, r8_)
        bus_write(14'h3F05, 8'hFF);
        bus_read(14'h3F05, 8'h3F, "R8 high bits dropped");
        bus_read(14'h3F25, 8'h3F, "R7 palette repeat 0x3F25");
        bus_read(14'h3FE5, 8'h3F, "R7 palette repeat 0x3FE5");
        bus_write(14'h3FFF, 8'h6A);
        bus_read(14'h3F1F, 8'h2A, "R7 last entry via 0x3FFF");
        bus_read(14'h3F00, 8'h00, "R7 boundary entry 0 untouched");

        // Pattern writes ignored (r3_)
        bus_write(14'h0410, 8'h99);
        bus_write(14'h0005, 8'h99);
        bus_write(14'h0010, 8'h99);
        bus_read(14'h2010, 8'h11, "R3 nametable 0x010 intact");
        bus_read(14'h2810, 8'h22, "R3 nametable 0x410 intact");
        bus_read(14'h3F05, 8'h3F, "R3 palette 5 intact");
        bus_read(14'h3F10, 8'h00, "R3 palette 0x10 intact");
        bus_read(14'h0410, rom_byte(13'h0410), "R3 pattern read unchanged");

        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(8'(sb_q.size()), 8'h00, "R9 every read returned");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule